// File: doc/BRIEF.md
# Alarm Match and Shared Interrupt/Square-Wave Pin

This block watches the running clock-calendar fields and compares them with a set of alarm values. Each of the six fields (seconds, minutes, hours, day of month, month, weekday) has its own enable bit. A field that is not enabled is ignored. An alarm hit needs every enabled field to be equal. The block turns hits into an alarm interrupt, in one of two forms. In latched form, a hit sets a status flag that stays set until software clears it. In pulsed form, each hit gives a pin pulse of fixed length and leaves the flag untouched.

The interrupt shares a single active-low open-drain pin with a square-wave output. The square wave is taken from one of fifteen prescaler taps, chosen by a 4-bit code, and code 0 switches the wave off. A mode input decides which of the two functions owns the pin. A separate enable decides whether the wave keeps running while the chip is on backup supply. The pin is released whenever its current owner is not pulling it low.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, `alarm_flag` is 0 and `pin_pull_low` is 0 (pin released).
- R2: Field i of `now_time` and `alm_time` occupies bits [8i+7:8i], with i = 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 weekday. A hit exists when `alm_en` is non-zero and every field whose `alm_en[i]` is 1 is equal. Fields with `alm_en[i]` = 0 have no effect on the hit.
- R3: With `alm_en` = 0 no hit ever occurs, whatever the time and alarm values.
- R4: An alarm event is the first cycle of a hit. A hit that stays present gives no further event until it has gone away and come back.
- R5: With `pulse_mode` = 0, an event sets `alarm_flag` at the next clock edge. The flag stays set until `flag_clr` is sampled high. While `use_freq` = 0, `pin_pull_low` follows the flag on the same edge.
- R6: When an event (with `pulse_mode` = 0) and `flag_clr` fall in the same cycle, the flag is set.
- R7: With `pulse_mode` = 1, an event drives `pin_pull_low` to 1 for exactly PULSE_LEN cycles, starting at the next edge, and `alarm_flag` is not set.
- R8: In pulse mode, an event during a running pulse restarts the PULSE_LEN count.
- R9: With `use_freq` = 1 and `freq_code` = k, where k is 1 to 15, the pin is pulled low one cycle after `taps[k-1]` is sampled low. `freq_code` = 0 releases the pin.
- R10: With `use_freq` = 1, `on_backup` = 1 and `freq_in_backup` = 0, the pin is released. With `freq_in_backup` = 1, the wave continues on backup.
- R11: With `use_freq` = 1 the interrupt does not drive the pin, but alarm events still set `alarm_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_time | input | 48 | Current time fields, 8 bits each |
| alm_time | input | 48 | Alarm compare values, same layout |
| alm_en | input | 6 | Per-field compare enables |
| taps | input | 15 | Prescaler square-wave taps, fastest at bit 0 |
| use_freq | input | 1 | 1: pin carries the square wave; 0: pin carries the interrupt |
| pulse_mode | input | 1 | 1: pulsed interrupt; 0: latched interrupt |
| freq_code | input | 4 | Tap select; 0 turns the wave off |
| on_backup | input | 1 | High while running from backup supply |
| freq_in_backup | input | 1 | Allows the wave while on backup supply |
| flag_clr | input | 1 | Clears the latched alarm flag |
| pin_pull_low | output | 1 | 1 drives the open-drain pin low |
| alarm_flag | output | 1 | Latched alarm status |

## Verification
The hardest case to reach is an event that arrives while earlier alarm state is still live: a second hit inside a running pulse, or a hit in the very cycle that clears the flag. Edge detection means a hit cannot simply be held. The stimulus first breaks the match by moving the seconds field, and then restores it on a chosen cycle. This places the new event a known number of cycles into the pulse, or in the same cycle as `flag_clr`. A behavioural model steps in parallel and is compared on every clock.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned FIELD_W  = 8;
  localparam int unsigned N_FIELDS = 6;
  localparam int unsigned N_TAPS   = 15;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_WDAY  = 3'd5
  } field_idx_e;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned NF = 6,
  parameter int unsigned FW = 8
) (
  input  logic [NF*FW-1:0] now_time,
  input  logic [NF*FW-1:0] alm_time,
  input  logic [NF-1:0]    alm_en,
  output logic             hit
);
  logic [NF-1:0] fld_ok;

  // A disabled field always counts as satisfied.
  for (genvar g = 0; g < NF; g++) begin : g_fld
    assign fld_ok[g] = !alm_en[g] || (now_time[g*FW +: FW] == alm_time[g*FW +: FW]);
  end

  assign hit = (|alm_en) && (&fld_ok);
endmodule

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen #(
  parameter int unsigned PULSE_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic pulse_mode,
  input  logic flag_clr,
  output logic flag_q,
  output logic irq_nxt
);
  localparam int unsigned CW = $clog2(PULSE_LEN + 1);

  logic          hit_q;
  logic          evt;
  logic          flag_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign evt = hit && !hit_q;

  always_comb begin
    flag_d = flag_q;
    if (evt && !pulse_mode)  flag_d = 1'b1;
    else if (flag_clr)       flag_d = 1'b0;

    cnt_d = cnt_q;
    if (evt && pulse_mode)   cnt_d = CW'(PULSE_LEN);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  assign cnt_en  = (evt && pulse_mode) || (cnt_q != '0);
  assign irq_nxt = pulse_mode ? (cnt_d != '0) : flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      hit_q  <= hit;
      flag_q <= flag_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rtc_freq_sel.sv
module rtc_freq_sel #(
  parameter int unsigned NT = 15
) (
  input  logic [NT-1:0]         taps,
  input  logic [$clog2(NT+1)-1:0] code,
  input  logic                  allow,
  output logic                  pull
);
  localparam int unsigned EW = NT + 1;
  logic [EW-1:0] ext;

  // Slot 0 is a constant high level so code 0 never pulls the pin.
  assign ext  = {taps, 1'b1};
  assign pull = allow && !ext[code];
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq #(
  parameter int unsigned PULSE_LEN = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [47:0] now_time,
  input  logic [47:0] alm_time,
  input  logic [5:0]  alm_en,
  input  logic [14:0] taps,
  input  logic        use_freq,
  input  logic        pulse_mode,
  input  logic [3:0]  freq_code,
  input  logic        on_backup,
  input  logic        freq_in_backup,
  input  logic        flag_clr,
  output logic        pin_pull_low,
  output logic        alarm_flag
);
  import rtc_alarm_pkg::*;

  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       hit;
  logic       irq_nxt;
  logic       wave_pull;
  logic       pin_d, pin_q;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  rtc_alarm_cmp #(.NF(N_FIELDS), .FW(FIELD_W)) u_cmp (
    .now_time (now_time),
    .alm_time (alm_time),
    .alm_en   (alm_en),
    .hit      (hit)
  );

  rtc_irq_gen #(.PULSE_LEN(PULSE_LEN)) u_irq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .hit        (hit),
    .pulse_mode (pulse_mode),
    .flag_clr   (flag_clr),
    .flag_q     (alarm_flag),
    .irq_nxt    (irq_nxt)
  );

  rtc_freq_sel #(.NT(N_TAPS)) u_freq (
    .taps  (taps),
    .code  (freq_code),
    .allow (!(on_backup && !freq_in_backup)),
    .pull  (wave_pull)
  );

  assign pin_d = use_freq ? wave_pull : irq_nxt;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pin_q <= 1'b0;
    else            pin_q <= pin_d;
  end

  assign pin_pull_low = pin_q;
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] alm_en,
  input logic       use_freq,
  input logic       pulse_mode,
  input logic [3:0] freq_code,
  input logic       on_backup,
  input logic       freq_in_backup,
  input logic       flag_clr,
  input logic       pin_pull_low,
  input logic       alarm_flag
);
  a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !flag_clr) |=> alarm_flag);

  a_r7_pulse_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && !alarm_flag) |=> !alarm_flag);

  a_r3_no_enable_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_en == 6'd0 && !alarm_flag) |=> !alarm_flag);

  a_r9_code0_released: assert property (@(posedge clk) disable iff (!rst_n)
    (use_freq && freq_code == 4'd0) |=> !pin_pull_low);

  a_r10_backup_released: assert property (@(posedge clk) disable iff (!rst_n)
    (use_freq && on_backup && !freq_in_backup) |=> !pin_pull_low);
endmodule

bind rtc_alarm_irq rtc_alarm_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .alm_en         (alm_en),
  .use_freq       (use_freq),
  .pulse_mode     (pulse_mode),
  .freq_code      (freq_code),
  .on_backup      (on_backup),
  .freq_in_backup (freq_in_backup),
  .flag_clr       (flag_clr),
  .pin_pull_low   (pin_pull_low),
  .alarm_flag     (alarm_flag)
);

// File: tb/rtc_alarm_irq_tb.sv
module rtc_alarm_irq_tb;
  localparam int PL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] now_time = '0, alm_time = '0;
  logic [5:0]  alm_en = '0;
  logic [15:0] tcnt = '0;
  logic [14:0] taps;
  logic        use_freq = 0, pulse_mode = 0, on_backup = 0, freq_in_backup = 0, flag_clr = 0;
  logic [3:0]  freq_code = '0;
  logic        pin_pull_low, alarm_flag;

  int checks = 0, errors = 0, wd = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  always @(posedge clk) tcnt <= tcnt + 16'd1;
  assign taps = tcnt[14:0];

  rtc_alarm_irq #(.PULSE_LEN(PL)) u_dut (
    .clk(clk), .rst_n(rst_n), .now_time(now_time), .alm_time(alm_time),
    .alm_en(alm_en), .taps(taps), .use_freq(use_freq), .pulse_mode(pulse_mode),
    .freq_code(freq_code), .on_backup(on_backup), .freq_in_backup(freq_in_backup),
    .flag_clr(flag_clr), .pin_pull_low(pin_pull_low), .alarm_flag(alarm_flag)
  );

  // Behavioural reference model
  bit m_prev, m_flag, m_pin;
  int m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = 0; m_flag = 0; m_cnt = 0; m_pin = 0;
    end else begin
      bit mt, ev, irq;
      mt = (alm_en != 0);
      for (int i = 0; i < 6; i++)
        if (alm_en[i] && now_time[i*8 +: 8] != alm_time[i*8 +: 8]) mt = 0;
      ev = mt && !m_prev;
      if (ev && !pulse_mode) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (ev && pulse_mode) m_cnt = PL;
      else if (m_cnt > 0) m_cnt--;
      irq = pulse_mode ? (m_cnt > 0) : m_flag;
      if (use_freq)
        m_pin = !(on_backup && !freq_in_backup) && freq_code != 0 && !taps[freq_code - 1];
      else
        m_pin = irq;
      m_prev = mt;
    end
  end

  task automatic chk(string r, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", r, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(cur_req, pin_pull_low, m_pin, "pin vs model");
    chk(cur_req, alarm_flag, m_flag, "flag vs model");
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic set_sec(logic [7:0] v); now_time[7:0] = v; endtask

  initial begin
    int cnt, tg;
    logic last;
    now_time = {8'd3, 8'd6, 8'd15, 8'd12, 8'd30, 8'd10};
    alm_time = {8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd20};
    tick(3); rst_n = 1; tick(4);
    chk("R1", alarm_flag, 0, "flag after reset");
    chk("R1", pin_pull_low, 0, "pin after reset");

    // R3: no enables, equal seconds
    cur_req = "R3"; set_sec(8'd20); tick(3);
    chk("R3", alarm_flag, 0, "no enables, no hit");
    set_sec(8'd10); tick(1);

    // R2: only seconds enabled; other fields differ
    cur_req = "R2"; alm_en = 6'b000001; tick(2);
    chk("R2", alarm_flag, 0, "mismatch seconds");
    set_sec(8'd20); tick(1);
    chk("R2", alarm_flag, 1, "seconds hit, others disabled");
    chk("R5", pin_pull_low, 1, "pin follows flag");
    // R5 hold and clear
    cur_req = "R5"; set_sec(8'd21); tick(5);
    chk("R5", alarm_flag, 1, "flag held");
    flag_clr = 1; tick(1); flag_clr = 0;
    chk("R5", alarm_flag, 0, "flag cleared");
    chk("R5", pin_pull_low, 0, "pin released");
    // R2 enabled non-matching field blocks hit
    cur_req = "R2"; alm_en = 6'b000011; set_sec(8'd20); tick(3);
    chk("R2", alarm_flag, 0, "minutes enabled and different");
    set_sec(8'd21); alm_time[15:8] = 8'd30; tick(1);
    set_sec(8'd20); tick(1);
    chk("R2", alarm_flag, 1, "seconds+minutes hit");
    // R4: held hit does not re-set after clear
    cur_req = "R4"; flag_clr = 1; tick(1); flag_clr = 0; tick(4);
    chk("R4", alarm_flag, 0, "held hit no new event");
    set_sec(8'd22); tick(1); set_sec(8'd20); tick(1);
    chk("R4", alarm_flag, 1, "hit returned gives event");
    // R6: event and clear together
    cur_req = "R6"; flag_clr = 1; tick(1); set_sec(8'd22); tick(1);
    set_sec(8'd20); tick(1); flag_clr = 0;
    chk("R6", alarm_flag, 1, "set beats clear");
    flag_clr = 1; tick(1); flag_clr = 0; set_sec(8'd22); tick(1);

    // R7: pulse mode length
    cur_req = "R7"; pulse_mode = 1; set_sec(8'd20); tick(1);
    cnt = 0;
    while (pin_pull_low && cnt < 50) begin cnt++; tick(1); end
    chk("R7", cnt == PL, 1, "pulse length equals PULSE_LEN");
    chk("R7", alarm_flag, 0, "no flag in pulse mode");
    // R8: retrigger mid pulse
    cur_req = "R8"; set_sec(8'd22); tick(1); set_sec(8'd20); tick(3);
    set_sec(8'd22); tick(1); set_sec(8'd20); tick(1);
    cnt = 0;
    while (pin_pull_low && cnt < 50) begin cnt++; tick(1); end
    chk("R8", cnt == PL, 1, "restarted pulse full length");
    set_sec(8'd22); pulse_mode = 0; tick(2);

    // R9: frequency codes
    cur_req = "R9"; use_freq = 1;
    for (int k = 0; k < 16; k++) begin freq_code = 4'(k); tick(40); end
    freq_code = 4'd1; tick(2); last = pin_pull_low; tg = 0;
    for (int i = 0; i < 10; i++) begin tick(1); if (pin_pull_low != last) tg++; last = pin_pull_low; end
    chk("R9", tg == 10, 1, "code 1 toggles every cycle");
    freq_code = 4'd0; tick(2);
    chk("R9", pin_pull_low, 0, "code 0 released");

    // R10: backup gating
    cur_req = "R10"; freq_code = 4'd3; on_backup = 1; tick(20);
    chk("R10", pin_pull_low, 0, "released on backup");
    freq_in_backup = 1; tick(20);
    on_backup = 0; freq_in_backup = 0;

    // R11: alarm in frequency mode
    cur_req = "R11"; freq_code = 4'd0; set_sec(8'd20); tick(1);
    chk("R11", alarm_flag, 1, "flag set in freq mode");
    tick(3);
    chk("R11", pin_pull_low, 0, "interrupt not on pin");
    tick(5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule